// File: doc/BRIEF.md
# TAP Master State Sequencer

This block drives the test-mode-select line of one or more boundary-scan target chains from the master side. A command names an operation and a stable end state. The operation is one of four: move, execute, instruction scan or data scan. The block then emits the TMS bit stream that walks every target TAP controller along the chosen path. An internal copy of the target state machine keeps track of where the targets are. The path logic uses it to choose the next bit toward the current goal. Execute holds the targets in Run-Test/Idle for a counted number of clocks. A scan steers the targets into Shift-IR or Shift-DR and keeps them there for a counted number of bits. The last bit carries TMS high so that the targets leave the shift state. The block then routes them to the requested end state.

Commands arrive on a valid/ready port that carries no buffer. `cmd_ready` is high only while the sequencer is idle. A command is taken on a rising clock edge that sees `cmd_valid` and `cmd_ready` both high. While `cmd_ready` is low, the source must hold `cmd_valid` and its payload. Completion raises `done`, which stays high until the next command is accepted, and pulses `irq` for one clock. The sequencer updates on the rising test-clock edge. The TMS line is re-timed to the falling edge and then fanned out to several output lines. The first lines are always TMS. Each of the others has its own select bit, since those pins may serve another purpose. An active-low disable input drops every target-side output enable.

An active-low test reset clears the block for as long as it is held low. After release, the block drives TMS high for a fixed number of clocks, which forces the targets into Test-Logic-Reset. Only then does it report ready.

Top module: `tapm_master`

## Requirements
- R1: While `trst_n` is low, `cmd_ready` and `done` are low and every TMS output is 1. After release, TMS stays 1 for exactly RESET_LEN rising edges with `cmd_ready` low. `cmd_ready` then rises and `cur_stable` reads 0 (Test-Logic-Reset).
- R2: A command is accepted on a rising edge with `cmd_valid` and `cmd_ready` high. On that edge `cmd_ready` and `done` go low. On completion, `done` rises together with `cmd_ready` and stays high until the next accepted command. `irq` pulses high for exactly one cycle per completed command.
- R3: `cmd_op` selects the operation: 0 move, 1 execute, 2 instruction scan, 3 data scan. `cmd_end` codes the stable states as 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Pause-DR, 3 Pause-IR, 4 Shift-DR and 5 Shift-IR. Every command leaves the targets in the state that `cmd_end` names. `cur_stable` reports the tracked target state with the same codes, or 7 for any non-stable state.
- R4: A move from Test-Logic-Reset to Run-Test/Idle emits the single bit 0. A move from Run-Test/Idle to Shift-DR emits 1,0,0. A move from Run-Test/Idle to Shift-IR emits 1,1,0,0.
- R5: A command whose end state is not Test-Logic-Reset never passes the targets through Test-Logic-Reset.
- R6: An execute command with count N gives exactly N rising edges on which the targets sit in Run-Test/Idle with TMS 0. The block then moves the targets to the end state.
- R7: A scan command with count N gives exactly N rising edges with the targets in the shift state that the scan selects. TMS is 0 on the first N-1 of those edges and 1 on the last.
- R8: A count of zero stands for 2^32 cycles. A data scan with count 0 is still in Shift-DR and not done after thousands of clocks.
- R9: A command with `cmd_end` of 6 or 7 is consumed and then ignored. `cmd_ready` stays high, and `done`, `irq` and `cur_stable` do not change.
- R10: The TMS outputs change only on falling edges of `tck`.
- R11: With `off_n` low, every bit of `tms_oe` and `tcko_oe` is 0. With `off_n` high, `tms_oe` bits below NUM_FIXED are 1, and bit i at or above NUM_FIXED equals `tms_sel[i-NUM_FIXED]`. All `tms_o` bits carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset, asynchronous assert |
| off_n | input | 1 | Active-low disable of all target-side outputs |
| tms_sel | input | NUM_TMS-NUM_FIXED | Enable for each shared TMS line |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 2 | Operation code |
| cmd_end | input | 3 | Requested end state code |
| cmd_count | input | CNT_W | Execute or scan length, 0 meaning 2^CNT_W |
| done | output | 1 | Last command finished |
| irq | output | 1 | One-cycle completion request |
| cur_stable | output | 3 | Tracked target state code |
| tms_o | output | NUM_TMS | TMS value on each line |
| tms_oe | output | NUM_TMS | Output enable of each TMS line |
| tcko | output | 1 | Test clock forwarded to targets |
| tcko_oe | output | 1 | Output enable of the forwarded clock |

## Verification
The bench builds the block with its defaults: six TMS lines with two fixed, a 32-bit counter and an eight-clock reset sequence. With these values, every enable-select combination of the four shared lines can be reached, and so can every pair of stable start and end states. The full 32-bit counter puts the zero-means-2^32 case out of reach of a complete run. That case is therefore shown by a data scan that is still shifting after thousands of clocks and is then ended by a test reset. Execute and scan lengths up to forty, including the single-bit scan, are checked against a separate target state model in the bench.

// File: rtl/tapm_pkg.sv
package tapm_pkg;

  typedef enum logic [3:0] {
    T_TLR, T_RTI, T_SELDR, T_CAPDR, T_SDR, T_E1DR, T_PDR, T_E2DR,
    T_UPDDR, T_SELIR, T_CAPIR, T_SIR, T_E1IR, T_PIR, T_E2IR, T_UPDIR
  } tap_e;

  typedef enum logic [1:0] {OP_MOVE, OP_EXEC, OP_SCAN_IR, OP_SCAN_DR} op_e;

  typedef enum logic [1:0] {PH_RST, PH_IDLE, PH_RUN, PH_POST} phase_e;

  localparam logic [2:0] SC_NONE = 3'd7;

  // one rising edge of the target controller
  function automatic tap_e tap_step(tap_e s, logic t);
    case (s)
      T_TLR:   return t ? T_TLR   : T_RTI;
      T_RTI:   return t ? T_SELDR : T_RTI;
      T_SELDR: return t ? T_SELIR : T_CAPDR;
      T_CAPDR: return t ? T_E1DR  : T_SDR;
      T_SDR:   return t ? T_E1DR  : T_SDR;
      T_E1DR:  return t ? T_UPDDR : T_PDR;
      T_PDR:   return t ? T_E2DR  : T_PDR;
      T_E2DR:  return t ? T_UPDDR : T_SDR;
      T_UPDDR: return t ? T_SELDR : T_RTI;
      T_SELIR: return t ? T_TLR   : T_CAPIR;
      T_CAPIR: return t ? T_E1IR  : T_SIR;
      T_SIR:   return t ? T_E1IR  : T_SIR;
      T_E1IR:  return t ? T_UPDIR : T_PIR;
      T_PIR:   return t ? T_E2IR  : T_PIR;
      T_E2IR:  return t ? T_UPDIR : T_SIR;
      default: return t ? T_SELDR : T_RTI;
    endcase
  endfunction

  // TMS bit that keeps a stable state where it is
  function automatic logic stay_bit(tap_e s);
    return (s == T_TLR);
  endfunction

  // next TMS bit on the way from s toward a different goal; the route
  // never enters Test-Logic-Reset unless that is the goal
  function automatic logic route_bit(tap_e s, tap_e goal);
    logic dr_goal;
    dr_goal = (goal == T_SDR) || (goal == T_PDR);
    case (s)
      T_TLR:   return goal == T_TLR;
      T_RTI:   return 1'b1;
      T_SELDR: return !(dr_goal || goal == T_RTI);
      T_CAPDR: return goal != T_SDR;
      T_SDR:   return goal != T_SDR;
      T_E1DR:  return goal != T_PDR;
      T_PDR:   return goal != T_PDR;
      T_E2DR:  return goal != T_SDR;
      T_UPDDR: return goal != T_RTI;
      T_SELIR: return goal == T_TLR;
      T_CAPIR: return goal != T_SIR;
      T_SIR:   return goal != T_SIR;
      T_E1IR:  return goal != T_PIR;
      T_PIR:   return goal != T_PIR;
      T_E2IR:  return goal != T_SIR;
      default: return goal != T_RTI;
    endcase
  endfunction

  function automatic tap_e code_to_tap(logic [2:0] c);
    case (c)
      3'd1:    return T_RTI;
      3'd2:    return T_PDR;
      3'd3:    return T_PIR;
      3'd4:    return T_SDR;
      3'd5:    return T_SIR;
      default: return T_TLR;
    endcase
  endfunction

  function automatic logic [2:0] tap_to_code(tap_e s);
    case (s)
      T_TLR:   return 3'd0;
      T_RTI:   return 3'd1;
      T_PDR:   return 3'd2;
      T_PIR:   return 3'd3;
      T_SDR:   return 3'd4;
      T_SIR:   return 3'd5;
      default: return SC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tapm_tracker.sv
module tapm_tracker
  import tapm_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms_line,
  output tap_e       tap,
  output tap_e       tap_nxt,
  output logic [2:0] cur_stable
);

  always_comb tap_nxt = tap_step(tap, tms_line);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) tap <= T_TLR;
    else         tap <= tap_nxt;
  end

  always_comb cur_stable = tap_to_code(tap);

endmodule

// File: rtl/tapm_seq.sv
module tapm_seq
  import tapm_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int RESET_LEN = 8
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [2:0]       cmd_end,
  input  logic [CNT_W-1:0] cmd_count,
  input  tap_e             tap,
  input  tap_e             tap_nxt,
  output logic             tms_next,
  output logic             done,
  output logic             irq,
  output logic             in_rst,
  output logic             last_shift
);

  localparam int RST_W = (RESET_LEN > 1) ? $clog2(RESET_LEN) : 1;
  localparam logic [RST_W-1:0] RST_INIT = RST_W'(RESET_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  phase_e           phase;
  op_e              op;
  tap_e             end_tap;
  tap_e             work_tap;
  logic [CNT_W-1:0] cnt;
  logic [RST_W-1:0] rst_cnt;
  logic             counting;
  logic             cnt_last;
  logic             end_ok;
  op_e              in_op;

  assign in_op     = op_e'(cmd_op);
  assign end_ok    = (cmd_end <= 3'd5);
  assign cmd_ready = (phase == PH_IDLE);
  assign in_rst    = (phase == PH_RST);
  assign counting  = (phase == PH_RUN) && (op != OP_MOVE) && (tap == work_tap);
  assign cnt_last  = (cnt == '0);
  assign last_shift = counting && cnt_last &&
                      ((op == OP_SCAN_IR) || (op == OP_SCAN_DR));

  always_comb begin
    case (phase)
      PH_RST:  tms_next = 1'b1;
      PH_IDLE: tms_next = stay_bit(tap);
      PH_RUN: begin
        if (tap != work_tap)    tms_next = route_bit(tap, work_tap);
        else if (op == OP_MOVE) tms_next = stay_bit(tap);
        else if (op == OP_EXEC) tms_next = 1'b0;
        else                    tms_next = cnt_last;
      end
      default: tms_next = (tap == end_tap) ? stay_bit(tap) : route_bit(tap, end_tap);
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      phase    <= PH_RST;
      rst_cnt  <= RST_INIT;
      op       <= OP_MOVE;
      end_tap  <= T_TLR;
      work_tap <= T_TLR;
      cnt      <= '0;
      done     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (phase)
        PH_RST: begin
          if (rst_cnt == '0) phase <= PH_IDLE;
          else               rst_cnt <= rst_cnt - 1'b1;
        end
        PH_IDLE: begin
          if (cmd_valid && end_ok) begin
            op      <= in_op;
            end_tap <= code_to_tap(cmd_end);
            case (in_op)
              OP_MOVE:    work_tap <= code_to_tap(cmd_end);
              OP_EXEC:    work_tap <= T_RTI;
              OP_SCAN_IR: work_tap <= T_SIR;
              default:    work_tap <= T_SDR;
            endcase
            cnt   <= cmd_count - CNT_ONE;
            done  <= 1'b0;
            phase <= PH_RUN;
          end
        end
        PH_RUN: begin
          if (op == OP_MOVE) begin
            if (tap_nxt == end_tap) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
              irq   <= 1'b1;
            end
          end else if (counting) begin
            if (cnt_last) begin
              if (tap_nxt == end_tap) begin
                phase <= PH_IDLE;
                done  <= 1'b1;
                irq   <= 1'b1;
              end else begin
                phase <= PH_POST;
              end
            end else begin
              cnt <= cnt - CNT_ONE;
            end
          end
        end
        default: begin
          if (tap_nxt == end_tap) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
            irq   <= 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/tapm_outdrv.sv
module tapm_outdrv #(
  parameter int NUM_TMS   = 6,
  parameter int NUM_FIXED = 2
) (
  input  logic                         tck,
  input  logic                         trst_n,
  input  logic                         off_n,
  input  logic [NUM_TMS-NUM_FIXED-1:0] tms_sel,
  input  logic                         tms_next,
  output logic                         tms_line,
  output logic [NUM_TMS-1:0]           tms_o,
  output logic [NUM_TMS-1:0]           tms_oe,
  output logic                         tcko,
  output logic                         tcko_oe
);

  // target side is launched on the falling edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tms_line <= 1'b1;
    else         tms_line <= tms_next;
  end

  for (genvar i = 0; i < NUM_TMS; i++) begin : g_line
    assign tms_o[i] = tms_line;
    if (i < NUM_FIXED) begin : g_fix
      assign tms_oe[i] = off_n;
    end else begin : g_shared
      assign tms_oe[i] = off_n & tms_sel[i-NUM_FIXED];
    end
  end

  assign tcko    = tck;
  assign tcko_oe = off_n;

endmodule

// File: rtl/tapm_master.sv
module tapm_master
  import tapm_pkg::*;
#(
  parameter int NUM_TMS   = 6,
  parameter int NUM_FIXED = 2,
  parameter int CNT_W     = 32,
  parameter int RESET_LEN = 8
) (
  input  logic                         tck,
  input  logic                         trst_n,
  input  logic                         off_n,
  input  logic [NUM_TMS-NUM_FIXED-1:0] tms_sel,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [1:0]                   cmd_op,
  input  logic [2:0]                   cmd_end,
  input  logic [CNT_W-1:0]             cmd_count,
  output logic                         done,
  output logic                         irq,
  output logic [2:0]                   cur_stable,
  output logic [NUM_TMS-1:0]           tms_o,
  output logic [NUM_TMS-1:0]           tms_oe,
  output logic                         tcko,
  output logic                         tcko_oe
);

  tap_e tap;
  tap_e tap_nxt;
  logic tms_next;
  logic tms_line;
  logic in_rst;
  logic last_shift;

  tapm_tracker u_trk (
    .tck        (tck),
    .trst_n     (trst_n),
    .tms_line   (tms_line),
    .tap        (tap),
    .tap_nxt    (tap_nxt),
    .cur_stable (cur_stable)
  );

  tapm_seq #(.CNT_W(CNT_W), .RESET_LEN(RESET_LEN)) u_seq (
    .tck        (tck),
    .trst_n     (trst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_end    (cmd_end),
    .cmd_count  (cmd_count),
    .tap        (tap),
    .tap_nxt    (tap_nxt),
    .tms_next   (tms_next),
    .done       (done),
    .irq        (irq),
    .in_rst     (in_rst),
    .last_shift (last_shift)
  );

  tapm_outdrv #(.NUM_TMS(NUM_TMS), .NUM_FIXED(NUM_FIXED)) u_drv (
    .tck      (tck),
    .trst_n   (trst_n),
    .off_n    (off_n),
    .tms_sel  (tms_sel),
    .tms_next (tms_next),
    .tms_line (tms_line),
    .tms_o    (tms_o),
    .tms_oe   (tms_oe),
    .tcko     (tcko),
    .tcko_oe  (tcko_oe)
  );

endmodule

// File: rtl/tapm_master_chk.sv
module tapm_master_chk (
  input logic       tck,
  input logic       trst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_end,
  input logic       done,
  input logic       irq,
  input logic [2:0] cur_stable,
  input logic       tms_line,
  input logic       in_rst,
  input logic       last_shift
);

  assert_rst_tms_R1: assert property (@(posedge tck) disable iff (!trst_n)
    in_rst |-> tms_line);

  assert_busy_not_done_R2: assert property (@(posedge tck) disable iff (!trst_n)
    !cmd_ready |-> !done);

  assert_irq_single_R2: assert property (@(posedge tck) disable iff (!trst_n)
    irq |=> !irq);

  assert_irq_with_done_R2: assert property (@(posedge tck) disable iff (!trst_n)
    irq |-> done);

  assert_accept_busy_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (cmd_valid && cmd_ready && cmd_end <= 3'd5) |=> (!cmd_ready && !done));

  assert_code_range_R3: assert property (@(posedge tck) disable iff (!trst_n)
    cur_stable != 3'd6);

  assert_last_bit_exit_R7: assert property (@(posedge tck) disable iff (!trst_n)
    last_shift |-> tms_line);

  assert_bad_end_ignored_R9: assert property (@(posedge tck) disable iff (!trst_n)
    (cmd_valid && cmd_ready && cmd_end > 3'd5) |=> (cmd_ready && $stable(done) && !irq));

endmodule

bind tapm_master tapm_master_chk u_chk (.*);

// File: tb/tapm_master_bench.sv
`timescale 1ns/100ps
module tapm_master_bench;

  localparam int NUM_TMS   = 6;
  localparam int NUM_FIXED = 2;
  localparam int CNT_W     = 32;
  localparam int RESET_LEN = 8;

  localparam int B_TLR = 0, B_RTI = 1, B_SELDR = 2, B_CAPDR = 3, B_SDR = 4,
                 B_E1DR = 5, B_PDR = 6, B_E2DR = 7, B_UPDDR = 8, B_SELIR = 9,
                 B_CAPIR = 10, B_SIR = 11, B_E1IR = 12, B_PIR = 13, B_E2IR = 14,
                 B_UPDIR = 15;

  logic                         tck = 1'b0;
  logic                         trst_n = 1'b0;
  logic                         off_n = 1'b1;
  logic [NUM_TMS-NUM_FIXED-1:0] tms_sel = '1;
  logic                         cmd_valid = 1'b0;
  logic                         cmd_ready;
  logic [1:0]                   cmd_op = '0;
  logic [2:0]                   cmd_end = '0;
  logic [CNT_W-1:0]             cmd_count = '0;
  logic                         done, irq;
  logic [2:0]                   cur_stable;
  logic [NUM_TMS-1:0]           tms_o, tms_oe;
  logic                         tcko, tcko_oe;

  always #2.5 tck = ~tck;

  tapm_master #(.NUM_TMS(NUM_TMS), .NUM_FIXED(NUM_FIXED), .CNT_W(CNT_W),
                .RESET_LEN(RESET_LEN)) u_tapm_master (
    .tck(tck), .trst_n(trst_n), .off_n(off_n), .tms_sel(tms_sel),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_end(cmd_end), .cmd_count(cmd_count), .done(done), .irq(irq),
    .cur_stable(cur_stable), .tms_o(tms_o), .tms_oe(tms_oe),
    .tcko(tcko), .tcko_oe(tcko_oe));

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nxt(int s, bit t);
    case (s)
      B_TLR:   return t ? B_TLR   : B_RTI;
      B_RTI:   return t ? B_SELDR : B_RTI;
      B_SELDR: return t ? B_SELIR : B_CAPDR;
      B_CAPDR, B_SDR: return t ? B_E1DR : B_SDR;
      B_E1DR:  return t ? B_UPDDR : B_PDR;
      B_PDR:   return t ? B_E2DR  : B_PDR;
      B_E2DR:  return t ? B_UPDDR : B_SDR;
      B_SELIR: return t ? B_TLR   : B_CAPIR;
      B_CAPIR, B_SIR: return t ? B_E1IR : B_SIR;
      B_E1IR:  return t ? B_UPDIR : B_PIR;
      B_PIR:   return t ? B_E2IR  : B_PIR;
      B_E2IR:  return t ? B_UPDIR : B_SIR;
      default: return t ? B_SELDR : B_RTI;   // both update states
    endcase
  endfunction

  function automatic int code_of(int s);
    case (s)
      B_TLR: return 0;
      B_RTI: return 1;
      B_PDR: return 2;
      B_PIR: return 3;
      B_SDR: return 4;
      B_SIR: return 5;
      default: return 7;
    endcase
  endfunction

  // bench target model and per-command observations
  int          m_st = B_TLR;
  bit          active = 0, fin = 0;
  int          nbits, rti_cnt, shift_cnt, shift_exit, shift_st, end_code;
  logic [31:0] seq;
  bit          saw_tlr;
  int          irq_cnt = 0;
  bit          rst_win = 1;
  int          rst_edges = 0, rst_ones = 0;
  int          edge_viol = 0;

  always @(posedge tck) begin
    if (irq) irq_cnt++;
    if (!trst_n) begin
      active = 0; rst_win = 1; rst_edges = 0; rst_ones = 0;
    end else if (rst_win) begin
      if (cmd_ready) rst_win = 0;
      else begin rst_edges++; if (tms_o[0]) rst_ones++; end
    end
    if (active && trst_n) begin
      if (done) begin
        active = 0; fin = 1;
      end else begin
        seq = {seq[30:0], tms_o[0]};
        nbits++;
        if (m_st == B_RTI && !tms_o[0]) rti_cnt++;
        if (m_st == shift_st) begin shift_cnt++; if (tms_o[0]) shift_exit++; end
        if (nxt(m_st, tms_o[0]) == B_TLR && end_code != 0) saw_tlr = 1;
      end
    end
    if (trst_n && cmd_valid && cmd_ready && cmd_end <= 3'd5) begin
      active = 1; fin = 0; nbits = 0; seq = 0; rti_cnt = 0; shift_cnt = 0;
      shift_exit = 0; saw_tlr = 0; end_code = int'(cmd_end);
      shift_st = (cmd_op == 2'd3) ? B_SDR : (cmd_op == 2'd2) ? B_SIR : -1;
    end
    m_st = nxt(m_st, tms_o[0]);
  end

  always @(tms_o) if (trst_n === 1'b1 && tck === 1'b1) edge_viol++;

  task automatic issue(input int op, input int e, input longint cnt);
    @(negedge tck);
    while (!cmd_ready) @(negedge tck);
    cmd_op = 2'(op); cmd_end = 3'(e); cmd_count = CNT_W'(cnt); cmd_valid = 1'b1;
    @(negedge tck);
    cmd_valid = 1'b0;
  endtask

  task automatic run_cmd(input int op, input int e, input longint cnt);
    int prev_irq;
    int guard;
    prev_irq = irq_cnt;
    issue(op, e, cnt);
    check(cmd_ready == 1'b0 && done == 1'b0, "R2", "busy after accept",
          {cmd_ready, done}, 0);
    guard = 0;
    while (!fin && guard < 5000) begin @(negedge tck); guard++; end
    check(fin, "R2", "command completes", fin, 1);
    check(done == 1'b1 && cmd_ready == 1'b1, "R2", "done and ready", {done, cmd_ready}, 3);
    check(irq_cnt == prev_irq + 1, "R2", "irq pulses", irq_cnt - prev_irq, 1);
    check(int'(cur_stable) == e, "R3", "reported end state", cur_stable, e);
    check(code_of(m_st) == e, "R3", "target end state", code_of(m_st), e);
    check(!saw_tlr, "R5", "no pass through reset", saw_tlr, 0);
    if (op == 1) check(rti_cnt == cnt, "R6", "idle clocks", rti_cnt, cnt);
    if (op >= 2) begin
      check(shift_cnt == cnt, "R7", "shift clocks", shift_cnt, cnt);
      check(shift_exit == 1, "R7", "single exit bit", shift_exit, 1);
    end
  endtask

  task automatic reset_seq();
    trst_n = 1'b0;
    repeat (4) @(negedge tck);
    check(cmd_ready == 1'b0 && done == 1'b0, "R1", "outputs in reset", {cmd_ready, done}, 0);
    check(tms_o == '1, "R1", "tms high in reset", tms_o, 63);
    trst_n = 1'b1;
    while (!cmd_ready) @(negedge tck);
    check(rst_edges == RESET_LEN, "R1", "reset clocks", rst_edges, RESET_LEN);
    check(rst_ones == RESET_LEN, "R1", "reset ones", rst_ones, RESET_LEN);
    check(cur_stable == 3'd0, "R1", "state after reset", cur_stable, 0);
  endtask

  initial begin
    #750000;
    check(0, "R2", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int prev_irq;
    int st_before;
    void'($urandom(32'd77123));
    reset_seq();

    // R4 directed paths
    run_cmd(0, 1, 0);
    check(nbits == 1 && seq == 0, "R4", "reset to idle path", seq, 0);
    run_cmd(0, 4, 0);
    check(nbits == 3 && seq == 32'b100, "R4", "idle to shift-dr path", seq, 4);
    run_cmd(0, 1, 0);
    run_cmd(0, 5, 0);
    check(nbits == 4 && seq == 32'b1100, "R4", "idle to shift-ir path", seq, 12);

    // R6 / R7 directed boundaries
    run_cmd(3, 2, 1);
    run_cmd(2, 3, 1);
    run_cmd(1, 1, 1);
    run_cmd(1, 0, 5);
    run_cmd(3, 1, 17);
    run_cmd(0, 0, 0);

    // R9 bad end code
    prev_irq = irq_cnt;
    st_before = int'(cur_stable);
    issue(0, 6, 3);
    repeat (6) @(negedge tck);
    check(cmd_ready && done, "R9", "ready and done kept", {cmd_ready, done}, 3);
    check(irq_cnt == prev_irq, "R9", "no irq", irq_cnt - prev_irq, 0);
    check(int'(cur_stable) == st_before, "R9", "state kept", cur_stable, st_before);

    // R11 output enables
    @(negedge tck);
    off_n = 1'b0; #1;
    check(tms_oe == '0 && tcko_oe == 1'b0, "R11", "disabled", {tcko_oe, tms_oe}, 0);
    off_n = 1'b1; tms_sel = 4'b1010; #1;
    check(tms_oe == 6'b101011 && tcko_oe, "R11", "selected enables", tms_oe, 43);
    tms_sel = 4'b0101; #1;
    check(tms_oe == 6'b010111, "R11", "selected enables b", tms_oe, 23);
    check(tms_o == '0 || tms_o == '1, "R11", "lines agree", tms_o, 0);
    tms_sel = '1;

    // random mix
    for (int k = 0; k < 40; k++) begin
      int op, e, c;
      op = int'($urandom % 4);
      e  = (op >= 2) ? int'($urandom % 4) : int'($urandom % 6);
      c  = 1 + int'($urandom % 40);
      run_cmd(op, e, c);
    end

    // R8 zero count means 2^32
    run_cmd(0, 1, 0);
    issue(3, 1, 0);
    repeat (3000) @(negedge tck);
    check(!done && !cmd_ready, "R8", "still busy", {done, cmd_ready}, 0);
    check(cur_stable == 3'd4, "R8", "still shifting", cur_stable, 4);
    reset_seq();

    check(edge_viol == 0, "R10", "tms changes on rising edge", edge_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule